// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block keeps a handful of recent virtual-page to physical-page translations close to the processor. It sits in front of a page table held in main memory. Each lookup compares the incoming virtual page number against every valid entry at once. On a hit, the physical page number and the entry's modified flag come back in the same cycle, so the page table is not read at all. On a miss, the block raises a miss indication. An external table walker then reads the page table entry and offers it back as a refill.

Only translations for pages present in memory are cached. A refill marked non-present produces a fault indication and is not stored. When the table walker refills a page that is already cached, the existing entry is updated. Otherwise the refill takes an empty slot, or else the entry used least recently. A write that hits a clean entry marks it modified and asks for the modified flag to be written back to the page table. A flush, issued when the active page table is swapped, drops every cached translation.

Top module: `tlb_cache`

## Requirements
- R1: After reset, no entry is valid, so every lookup reports a miss until a refill is installed.
- R2: A lookup (`lkp_valid`=1) whose page number matches a valid entry asserts `hit` in the same cycle. It also drives that entry's physical page number on `hit_ppn` and its stored modified flag on `hit_dirty`.
- R3: A lookup that matches no valid entry asserts `miss` in the same cycle. `hit` and `miss` are never both high, and both are low when `lkp_valid`=0.
- R4: A refill with `fill_present`=1 stores the given page numbers and modified flag. The new entry answers lookups from the next cycle on.
- R5: A refill with `fill_present`=0 raises `fault` in the same cycle and changes no stored translation.
- R6: A refill whose page number is already cached overwrites that entry in place. No second copy is created and no other entry is evicted.
- R7: A refill of a new page number goes to the lowest-numbered empty entry. When every entry is full, it goes to the entry whose last hit or refill is oldest. Both hits and refills count as use.
- R8: A write lookup (`lkp_write`=1) that hits an entry with a clear modified flag pulses `dirty_wb` in that cycle, with the page number on `dirty_wb_vpn`. From the next cycle on, the entry reports `hit_dirty`=1. A read hit, or a write hit on an already modified entry, leaves `dirty_wb` low.
- R9: `flush` invalidates every entry in a single cycle. A lookup in the flush cycle reports a miss. A refill offered in the flush cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_write | input | 1 | Lookup is for a store |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| hit | output | 1 | Lookup found a valid translation |
| miss | output | 1 | Lookup found no valid translation |
| hit_ppn | output | PPN_W | Physical page number of the hit entry |
| hit_dirty | output | 1 | Stored modified flag of the hit entry |
| dirty_wb | output | 1 | Request to write the modified flag back to the page table |
| dirty_wb_vpn | output | VPN_W | Page whose modified flag must be written back |
| fill_valid | input | 1 | Refill offered by the table walker |
| fill_present | input | 1 | Refilled page is present in memory |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_dirty | input | 1 | Refill modified flag |
| fault | output | 1 | Refill was for a non-present page |
| flush | input | 1 | Invalidate all translations |

## Verification
A damaged valid bit or a stale page number shows up at the very next lookup of that page. It appears as a wrong hit or miss, or as a wrong `hit_ppn`, in the same cycle as the lookup. A corrupted recency order stays hidden until the buffer is full and a refill evicts the wrong page. The bench therefore fills every entry, refreshes one entry, refills once more, and checks exactly which page disappeared. A lost modified-flag update shows up as a second `dirty_wb` pulse on the following write to the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned TLB_ENTRIES_DEF = 8;
    localparam int unsigned TLB_VPN_W_DEF   = 20;
    localparam int unsigned TLB_PPN_W_DEF   = 18;

    // what a refill does to the array in the cycle it is offered
    typedef enum logic [1:0] {
        FILL_IDLE   = 2'd0,
        FILL_FAULT  = 2'd1,
        FILL_UPDATE = 2'd2,
        FILL_ALLOC  = 2'd3
    } fill_act_e;

    function automatic fill_act_e classify_fill(
        input logic valid,
        input logic present,
        input logic flush,
        input logic already_cached
    );
        if (!valid)
            return FILL_IDLE;
        else if (!present)
            return FILL_FAULT;
        else if (flush)
            return FILL_IDLE;
        else if (already_cached)
            return FILL_UPDATE;
        else
            return FILL_ALLOC;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int unsigned N    = 8,
    parameter int unsigned VW   = 20,
    parameter int unsigned PW   = 18,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [VW-1:0] lkp_vpn,
    input  logic [VW-1:0] fill_vpn,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [PW-1:0] wr_ppn,
    input  logic          wr_dirty,
    input  logic          mark_en,
    input  logic [IW-1:0] mark_idx,
    output logic [N-1:0]  lkp_match,
    output logic [N-1:0]  fill_match,
    output logic [N-1:0]  valid_vec,
    output logic [PW-1:0] rd_ppn,
    output logic          rd_dirty
);

    logic [VW-1:0] vpn_q   [N];
    logic [PW-1:0] ppn_q   [N];
    logic [N-1:0]  dirty_q;
    logic [N-1:0]  valid_q;
    logic [PW-1:0] ppn_masked [N];

    assign valid_vec = valid_q;

    for (genvar g = 0; g < N; g++) begin : g_entry
        localparam logic [IW-1:0] MY_IDX = IW'(g);

        assign lkp_match[g]  = valid_q[g] && (vpn_q[g] == lkp_vpn);
        assign fill_match[g] = valid_q[g] && (vpn_q[g] == fill_vpn);
        assign ppn_masked[g] = lkp_match[g] ? ppn_q[g] : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
                ppn_q[g]   <= '0;
            end else if (flush) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == MY_IDX) begin
                valid_q[g] <= 1'b1;
                vpn_q[g]   <= fill_vpn;
                ppn_q[g]   <= wr_ppn;
                dirty_q[g] <= wr_dirty;
            end else if (mark_en && mark_idx == MY_IDX) begin
                dirty_q[g] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_ppn = '0;
        for (int i = 0; i < N; i++)
            rd_ppn = rd_ppn | ppn_masked[i];
    end

    assign rd_dirty = |(lkp_match & dirty_q);

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int unsigned N   = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid_vec,
    output logic [IW-1:0] victim_idx
);

    logic [IW-1:0] age_q [N];
    logic [IW-1:0] touched_age;

    always_comb begin
        touched_age = '0;
        for (int i = 0; i < N; i++)
            if (touch_idx == IW'(i))
                touched_age = age_q[i];
    end

    // ages always form a permutation of 0..N-1; 0 is most recent
    for (genvar g = 0; g < N; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst)
                age_q[g] <= IW'(g);
            else if (touch_en) begin
                if (touch_idx == IW'(g))
                    age_q[g] <= '0;
                else if (age_q[g] < touched_age)
                    age_q[g] <= age_q[g] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found_free;
        found_free = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++)
            if (age_q[i] == IW'(N - 1))
                victim_idx = IW'(i);
        for (int i = 0; i < N; i++)
            if (!found_free && !valid_vec[i]) begin
                found_free = 1'b1;
                victim_idx = IW'(i);
            end
    end

endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int unsigned N     = TLB_ENTRIES_DEF,
    parameter int unsigned VPN_W = TLB_VPN_W_DEF,
    parameter int unsigned PPN_W = TLB_PPN_W_DEF,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lkp_valid,
    input  logic             lkp_write,
    input  logic [VPN_W-1:0] lkp_vpn,
    output logic             hit,
    output logic             miss,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_dirty,
    output logic             dirty_wb,
    output logic [VPN_W-1:0] dirty_wb_vpn,
    input  logic             fill_valid,
    input  logic             fill_present,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_dirty,
    output logic             fault,
    input  logic             flush
);

    logic [N-1:0]  lkp_match;
    logic [N-1:0]  fill_match;
    logic [N-1:0]  valid_vec;
    logic [PPN_W-1:0] rd_ppn;
    logic          rd_dirty;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] dup_idx;
    logic [IW-1:0] victim_idx;
    logic [IW-1:0] wr_idx;
    logic          wr_en;
    logic          mark_en;
    logic          touch_en;
    logic [IW-1:0] touch_idx;
    fill_act_e     fill_act;

    always_comb begin
        hit_idx = '0;
        dup_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lkp_match[i])  hit_idx = IW'(i);
            if (fill_match[i]) dup_idx = IW'(i);
        end
    end

    assign hit       = lkp_valid && !flush && (|lkp_match);
    assign miss      = lkp_valid && !hit;
    assign hit_ppn   = hit ? rd_ppn : '0;
    assign hit_dirty = hit && rd_dirty;

    assign dirty_wb     = hit && lkp_write && !rd_dirty;
    assign dirty_wb_vpn = dirty_wb ? lkp_vpn : '0;

    assign fill_act = classify_fill(fill_valid, fill_present, flush, |fill_match);
    assign fault    = (fill_act == FILL_FAULT);
    assign wr_en    = (fill_act == FILL_UPDATE) || (fill_act == FILL_ALLOC);
    assign wr_idx   = (fill_act == FILL_UPDATE) ? dup_idx : victim_idx;
    assign mark_en  = dirty_wb;

    // a refill takes precedence over a hit for the recency update
    assign touch_en  = wr_en || hit;
    assign touch_idx = wr_en ? wr_idx : hit_idx;

    tlb_store #(.N(N), .VW(VPN_W), .PW(PPN_W)) store_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .lkp_vpn    (lkp_vpn),
        .fill_vpn   (fill_vpn),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_ppn     (fill_ppn),
        .wr_dirty   (fill_dirty),
        .mark_en    (mark_en),
        .mark_idx   (hit_idx),
        .lkp_match  (lkp_match),
        .fill_match (fill_match),
        .valid_vec  (valid_vec),
        .rd_ppn     (rd_ppn),
        .rd_dirty   (rd_dirty)
    );

    tlb_lru #(.N(N)) lru_i (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         lkp_valid,
    input logic         lkp_write,
    input logic         hit,
    input logic         miss,
    input logic         hit_dirty,
    input logic         dirty_wb,
    input logic         fill_valid,
    input logic         fill_present,
    input logic         fault,
    input logic         flush,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] lkp_match,
    input logic [N-1:0] fill_match
);

    // R1
    empty_after_reset_chk: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));

    // R3
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss) && (lkp_valid || (!hit && !miss)));

    // R6
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lkp_match) && $onehot0(fill_match));

    // R5
    absent_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_present && !flush && !dirty_wb) |=> $stable(valid_vec));

    // R5
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fill_valid && !fill_present));

    // R8
    wb_only_clean_write_chk: assert property (@(posedge clk) disable iff (rst)
        dirty_wb |-> (hit && lkp_write && !hit_dirty));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R9
    flush_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !hit);

endmodule

bind tlb_cache tlb_chk #(.N(N)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .lkp_valid    (lkp_valid),
    .lkp_write    (lkp_write),
    .hit          (hit),
    .miss         (miss),
    .hit_dirty    (hit_dirty),
    .dirty_wb     (dirty_wb),
    .fill_valid   (fill_valid),
    .fill_present (fill_present),
    .fault        (fault),
    .flush        (flush),
    .valid_vec    (valid_vec),
    .lkp_match    (lkp_match),
    .fill_match   (fill_match)
);

// File: tb/tlb_cache_tb.sv
module tlb_cache_tb_top;

    localparam int VW = 20;
    localparam int PW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lkp_valid = 1'b0;
    logic          lkp_write = 1'b0;
    logic [VW-1:0] lkp_vpn = '0;
    logic          hit, miss, hit_dirty, dirty_wb, fault;
    logic [PW-1:0] hit_ppn;
    logic [VW-1:0] dirty_wb_vpn;
    logic          fill_valid = 1'b0;
    logic          fill_present = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic          fill_dirty = 1'b0;
    logic          flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tlb_cache dut_i (
        .clk(clk), .rst(rst),
        .lkp_valid(lkp_valid), .lkp_write(lkp_write), .lkp_vpn(lkp_vpn),
        .hit(hit), .miss(miss), .hit_ppn(hit_ppn), .hit_dirty(hit_dirty),
        .dirty_wb(dirty_wb), .dirty_wb_vpn(dirty_wb_vpn),
        .fill_valid(fill_valid), .fill_present(fill_present),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
        .fault(fault), .flush(flush)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive a lookup at the falling edge, sample mid-cycle, release next falling edge
    task automatic probe(input logic [VW-1:0] vpn, input logic wr, input bit exp_hit,
                         input logic [PW-1:0] exp_ppn, input string req);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_write = wr; lkp_vpn = vpn;
        #2;
        check(hit == exp_hit && miss == !exp_hit, req, {hit, miss}, {exp_hit, !exp_hit});
        if (exp_hit)
            check(hit_ppn == exp_ppn, req, hit_ppn, exp_ppn);
        @(negedge clk);
        lkp_valid = 1'b0; lkp_write = 1'b0;
    endtask

    task automatic refill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                          input logic d, input logic present);
        @(negedge clk);
        fill_valid = 1'b1; fill_present = present;
        fill_vpn = vpn; fill_ppn = ppn; fill_dirty = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        probe(20'h00000, 1'b0, 0, '0, "R1");
        probe(20'h00123, 1'b0, 0, '0, "R1");
        #2 check(!hit && !miss, "R3", {hit, miss}, 0);
    endtask

    task automatic t_basic();
        refill(20'h00ABC, 18'h0155, 1'b1, 1'b1);
        probe(20'h00ABC, 1'b0, 1, 18'h0155, "R4");
        probe(20'h00ABC, 1'b0, 1, 18'h0155, "R2");
        @(negedge clk);
        lkp_valid = 1'b1; lkp_vpn = 20'h00ABC; #2;
        check(hit_dirty == 1'b1, "R2", hit_dirty, 1);
        @(negedge clk); lkp_valid = 1'b0;
        probe(20'h00ABD, 1'b0, 0, '0, "R3");
    endtask

    task automatic t_fault();
        @(negedge clk);
        fill_valid = 1'b1; fill_present = 1'b0; fill_vpn = 20'h00777; fill_ppn = 18'h0001;
        #2 check(fault == 1'b1, "R5", fault, 1);
        @(negedge clk);
        fill_valid = 1'b0;
        #2 check(fault == 1'b0, "R5", fault, 0);
        probe(20'h00777, 1'b0, 0, '0, "R5");
        probe(20'h00ABC, 1'b0, 1, 18'h0155, "R5");
    endtask

    task automatic t_dirty();
        refill(20'h00D00, 18'h0222, 1'b0, 1'b1);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_write = 1'b0; lkp_vpn = 20'h00D00; #2;
        check(dirty_wb == 1'b0 && hit_dirty == 1'b0, "R8", {dirty_wb, hit_dirty}, 0);
        @(negedge clk);
        lkp_write = 1'b1; #2;
        check(dirty_wb == 1'b1, "R8", dirty_wb, 1);
        check(dirty_wb_vpn == 20'h00D00, "R8", dirty_wb_vpn, 20'h00D00);
        check(hit_dirty == 1'b0, "R8", hit_dirty, 0);
        @(negedge clk);
        #2;
        check(dirty_wb == 1'b0 && hit_dirty == 1'b1, "R8", {dirty_wb, hit_dirty}, 1);
        @(negedge clk);
        lkp_valid = 1'b0; lkp_write = 1'b0;
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1; lkp_valid = 1'b1; lkp_vpn = 20'h00ABC; #2;
        check(!hit && miss, "R9", {hit, miss}, 1);
        @(negedge clk);
        flush = 1'b0; lkp_valid = 1'b0;
        probe(20'h00ABC, 1'b0, 0, '0, "R9");
        probe(20'h00D00, 1'b0, 0, '0, "R9");
        // refill offered during a flush is dropped
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_present = 1'b1;
        fill_vpn = 20'h00E00; fill_ppn = 18'h0333;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        probe(20'h00E00, 1'b0, 0, '0, "R9");
    endtask

    task automatic t_lru();
        for (int i = 0; i < 8; i++)
            refill(20'h00100 + VW'(i), 18'h0200 + PW'(i), 1'b0, 1'b1);
        probe(20'h00100, 1'b0, 1, 18'h0200, "R7");
        refill(20'h00108, 18'h0208, 1'b0, 1'b1);
        probe(20'h00101, 1'b0, 0, '0, "R7");
        probe(20'h00100, 1'b0, 1, 18'h0200, "R7");
        probe(20'h00108, 1'b0, 1, 18'h0208, "R7");
    endtask

    task automatic t_overwrite();
        refill(20'h00103, 18'h03AA, 1'b0, 1'b1);
        probe(20'h00103, 1'b0, 1, 18'h03AA, "R6");
        probe(20'h00100, 1'b0, 1, 18'h0200, "R6");
        probe(20'h00102, 1'b0, 1, 18'h0202, "R6");
        for (int i = 4; i < 9; i++)
            probe(20'h00100 + VW'(i), 1'b0, 1, 18'h0200 + PW'(i), "R6");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_fault();
        t_dirty();
        t_flush();
        t_lru();
        t_overwrite();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule